// File: doc/BRIEF.md
# Indexed Register Port with Auto-Increment

This block is the host-side register front end of a display controller. A host drives a 16-bit parallel bus with one extra select line that marks each transfer as a command or as data. A command write loads an 8-bit register index. Data transfers that follow then reach the register the index names, and the index moves on by itself, so a host can fill consecutive registers without sending a fresh command each time. Three streaming ports keep the index fixed, so a burst of data words stays on the same port.

Two tables sit behind index/data port pairs: a 256-entry gamma table whose index wraps, and a 32-entry filter coefficient table whose index stops the port from working once it steps past the last entry. The block also holds the configuration registers with their write masks, two read-only identity constants, an interrupt status register that is cleared by writing zeros into it, and a skip counter that makes the block silently swallow a chosen number of upcoming transfers.

Transfers use a valid/ready handshake. Words written to the pixel data port leave through a valid/ready output stream; while a word there waits for its consumer, the host port holds ready low, so no transfer of any kind is taken until the consumer drains it. Read data comes back one cycle after the read is accepted, marked by `rd_valid`; it has no back-pressure.

Top module: `host_regport`

## Requirements
- R1: After reset the index and the skip count are 0. An accepted write with `acc_dsel` = 0 (command) loads the index from `acc_wdata[7:0]`.
- R2: An accepted data write (`acc_dsel` = 1) updates the indexed register and then adds 2 to the index modulo 256, except at indices 0x90, 0x5A and 0xB8, where the index stays unchanged.
- R3: An accepted read returns the indexed register's 8-bit value, zero-extended, on `rd_data` with `rd_valid` high in the cycle after acceptance. With `acc_dsel` = 1 the index then advances by 1; with `acc_dsel` = 0 it is left alone. `rd_valid` is low otherwise.
- R4: A pulse on `skip_load` sets the skip count to `skip_count`. While the count is nonzero, each accepted transfer only decrements it: no register, table, index or output changes, and a read returns 0.
- R5: Index 0x00 reads 0xA5 and index 0x02 reads 0x83; both ignore writes. The pixel port 0x90 and every unlisted index read 0, and writes to unlisted indices change nothing.
- R6: A write to the clock divider at 0x04 stores (value & 0x3F) + 1; reading 0x04 gives (stored − 1) with bit 7 set. After reset it reads 0x88.
- R7: The 12-bit refresh interval is written in two halves: 0x18 sets bits 7:0 from value[7:0] and 0x1A sets bits 11:8 from value[3:0]. The two indices read back the same fields. Reset value 0x25C.
- R8: Write masks: timing at 0x1E keeps mask 0x17 (reset 0x13); input format at 0x8C keeps mask 0x0F (reset 3); filter setup at 0x56 keeps mask 0xBF (reset 0x80). Bits outside a mask read 0, and bits 15:8 of every readback are 0.
- R9: 0xB6 holds the 8-bit gamma index. Any non-skipped access to 0xB8 reads or writes gamma entry [index] and then increments the index, wrapping from 0xFF to 0x00.
- R10: 0x58 writes the filter index as value & 0x1F and reads back an index that may reach 32. A non-skipped access to 0x5A with index below 32 reads or writes that entry and increments the index; at index 32 it reads 0, writes nothing and leaves the index.
- R11: Interrupt status at 0xF6: a write replaces it with (status AND value[7:0]); a bit set on `irq_events` in a cycle is set in status at that edge, winning over a clear. `irq_pending` is high when any status bit is set.
- R12: A non-skipped data write at 0x90 puts `acc_wdata` on `px_data` with `px_valid` high from the next cycle; `px_valid` and `px_data` hold until `px_ready` is high, and `acc_ready` is low while a held word is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Host transfer request |
| acc_ready | output | 1 | Block can take a transfer this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_dsel | input | 1 | 1 = data transfer, 0 = command transfer |
| acc_wdata | input | 16 | Write data or command index |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rd_data | output | 16 | Read data |
| skip_load | input | 1 | Load the skip count |
| skip_count | input | SKIP_W | Number of transfers to swallow |
| irq_events | input | 8 | Interrupt event pulses, one bit per source |
| irq_pending | output | 1 | Any interrupt status bit set |
| px_valid | output | 1 | Pixel data word available |
| px_ready | input | 1 | Pixel consumer takes the word |
| px_data | output | 16 | Pixel data word |

## Verification
The bench builds the block with its default parameters: a 256-entry gamma table, a 32-entry filter table and a 4-bit skip counter. With these sizes a full pass over the gamma table is short enough to reach the index wrap from 0xFF to 0x00, and filling all 32 filter entries drives that index onto its dead value of 32. A reference model in the bench tracks every register, both tables, the index and the skip count. Seeded random command, data and read transfers, together with skip loads and interrupt pulses, are compared against this model after a directed pass over the corner cases.

// File: rtl/regport_pkg.sv
package regport_pkg;
  localparam int IDX_W  = 8;
  localparam int BYTE_W = 8;
  localparam int BUS_W  = 16;
  localparam int IRQ_W  = 8;
  localparam int REF_W  = 12;

  typedef logic [IDX_W-1:0] idx_t;

  localparam idx_t A_IDENT = 8'h00;
  localparam idx_t A_CFGRB = 8'h02;
  localparam idx_t A_DIV   = 8'h04;
  localparam idx_t A_RFLO  = 8'h18;
  localparam idx_t A_RFHI  = 8'h1A;
  localparam idx_t A_TIM   = 8'h1E;
  localparam idx_t A_FCFG  = 8'h56;
  localparam idx_t A_FIDX  = 8'h58;
  localparam idx_t A_FDAT  = 8'h5A;
  localparam idx_t A_FMT   = 8'h8C;
  localparam idx_t A_PIX   = 8'h90;
  localparam idx_t A_GIDX  = 8'hB6;
  localparam idx_t A_GDAT  = 8'hB8;
  localparam idx_t A_IRQ   = 8'hF6;

  localparam logic [7:0] IDENT_VAL = 8'hA5;
  localparam logic [7:0] CFGRB_VAL = 8'h83;

  localparam logic [7:0] M_DIV  = 8'h3F;
  localparam logic [7:0] M_TIM  = 8'h17;
  localparam logic [7:0] M_FMT  = 8'h0F;
  localparam logic [7:0] M_FCFG = 8'hBF;

  localparam logic [6:0]       RST_DIV  = 7'd9;
  localparam logic [REF_W-1:0] RST_REF  = 12'h25C;
  localparam logic [7:0]       RST_TIM  = 8'h13;
  localparam logic [3:0]       RST_FMT  = 4'd3;
  localparam logic [7:0]       RST_FCFG = 8'h80;

  // Streaming ports keep the index fixed on data writes
  function automatic logic is_stream(input idx_t a);
    return (a == A_PIX) || (a == A_FDAT) || (a == A_GDAT);
  endfunction
endpackage

// File: rtl/rp_index_ctrl.sv
module rp_index_ctrl
  import regport_pkg::*;
#(
  parameter int SKIP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              acc_write,
  input  logic              acc_dsel,
  input  idx_t              cmd_idx,
  input  logic              skip_load,
  input  logic [SKIP_W-1:0] skip_count,
  output idx_t              idx_q,
  output logic [SKIP_W-1:0] skip_q,
  output logic              discard
);
  assign discard = (skip_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      skip_q <= '0;
    end else begin
      if (fire && !discard) begin
        if (acc_write && !acc_dsel)
          idx_q <= cmd_idx;
        else if (acc_write) begin
          if (!is_stream(idx_q))
            idx_q <= idx_q + IDX_W'(2);
        end else if (acc_dsel)
          idx_q <= idx_q + IDX_W'(1);
      end
      if (skip_load)
        skip_q <= skip_count;
      else if (fire && discard)
        skip_q <= skip_q - SKIP_W'(1);
    end
  end
endmodule

// File: rtl/rp_table.sv
module rp_table #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  parameter bit GUARD = 1'b0,
  localparam int AW   = $clog2(DEPTH),
  localparam int IW   = GUARD ? AW + 1 : AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_wr,
  input  logic [AW-1:0] idx_wdata,
  input  logic          dat_wr,
  input  logic          dat_rd,
  input  logic [DW-1:0] dat_wdata,
  output logic [IW-1:0] idx_q,
  output logic [DW-1:0] dat_q
);
  logic [DW-1:0] mem [DEPTH];
  logic          in_rng;

  generate
    if (GUARD) begin : g_guard
      assign in_rng = ~idx_q[AW];
    end else begin : g_wrap
      assign in_rng = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)
      idx_q <= '0;
    else if (idx_wr)
      idx_q <= IW'(idx_wdata);
    else if ((dat_wr || dat_rd) && in_rng)
      idx_q <= idx_q + IW'(1);
  end

  always_ff @(posedge clk) begin
    if (dat_wr && in_rng)
      mem[idx_q[AW-1:0]] <= dat_wdata;
  end

  assign dat_q = in_rng ? mem[idx_q[AW-1:0]] : '0;
endmodule

// File: rtl/rp_cfg_regs.sv
module rp_cfg_regs
  import regport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  idx_t             addr,
  input  logic [7:0]       wdata,
  input  logic [IRQ_W-1:0] irq_events,
  output logic [7:0]       rd_val,
  output logic [IRQ_W-1:0] irq_q
);
  logic [6:0]       div_q;
  logic [REF_W-1:0] ref_q;
  logic [7:0]       tim_q;
  logic [3:0]       fmt_q;
  logic [7:0]       fcfg_q;
  logic [IRQ_W-1:0] irq_keep;

  assign irq_keep = (wr_en && addr == A_IRQ) ? (irq_q & wdata[IRQ_W-1:0]) : irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= RST_DIV;
      ref_q  <= RST_REF;
      tim_q  <= RST_TIM;
      fmt_q  <= RST_FMT;
      fcfg_q <= RST_FCFG;
      irq_q  <= '0;
    end else begin
      irq_q <= irq_keep | irq_events;
      if (wr_en) begin
        unique case (addr)
          A_DIV:   div_q  <= 7'(wdata & M_DIV) + 7'd1;
          A_RFLO:  ref_q[7:0]  <= wdata;
          A_RFHI:  ref_q[11:8] <= wdata[3:0];
          A_TIM:   tim_q  <= wdata & M_TIM;
          A_FMT:   fmt_q  <= 4'(wdata & M_FMT);
          A_FCFG:  fcfg_q <= wdata & M_FCFG;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (addr)
      A_DIV:   rd_val = {1'b1, div_q - 7'd1};
      A_RFLO:  rd_val = ref_q[7:0];
      A_RFHI:  rd_val = {4'h0, ref_q[11:8]};
      A_TIM:   rd_val = tim_q;
      A_FMT:   rd_val = {4'h0, fmt_q};
      A_FCFG:  rd_val = fcfg_q;
      A_IRQ:   rd_val = 8'(irq_q);
      default: rd_val = 8'h00;
    endcase
  end
endmodule

// File: rtl/host_regport.sv
module host_regport
  import regport_pkg::*;
#(
  parameter int GAMMA_DEPTH = 256,
  parameter int FILT_DEPTH  = 32,
  parameter int SKIP_W      = 4,
  localparam int GAW        = $clog2(GAMMA_DEPTH),
  localparam int FAW        = $clog2(FILT_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic              acc_write,
  input  logic              acc_dsel,
  input  logic [15:0]       acc_wdata,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  input  logic              skip_load,
  input  logic [SKIP_W-1:0] skip_count,
  input  logic [7:0]        irq_events,
  output logic              irq_pending,
  output logic              px_valid,
  input  logic              px_ready,
  output logic [15:0]       px_data
);
  idx_t              cur_idx;
  logic [SKIP_W-1:0] skip_cnt;
  logic              discard;
  logic              fire, eff_wr, eff_rd;
  logic [7:0]        cfg_rd, rd_mux;
  logic [IRQ_W-1:0]  irq_q;
  logic [GAW-1:0]    gidx_q;
  logic [FAW:0]      fidx_q;
  logic [7:0]        gdat_q, fdat_q;

  assign acc_ready = !px_valid || px_ready;
  assign fire      = acc_valid && acc_ready;
  assign eff_wr    = fire && !discard && acc_write && acc_dsel;
  assign eff_rd    = fire && !discard && !acc_write;

  rp_index_ctrl #(.SKIP_W(SKIP_W)) u_idx (
    .clk, .rst_n, .fire, .acc_write, .acc_dsel,
    .cmd_idx(acc_wdata[IDX_W-1:0]), .skip_load, .skip_count,
    .idx_q(cur_idx), .skip_q(skip_cnt), .discard
  );

  rp_cfg_regs u_cfg (
    .clk, .rst_n, .wr_en(eff_wr), .addr(cur_idx), .wdata(acc_wdata[7:0]),
    .irq_events, .rd_val(cfg_rd), .irq_q
  );

  rp_table #(.DEPTH(GAMMA_DEPTH), .DW(8), .GUARD(1'b0)) u_gamma (
    .clk, .rst_n,
    .idx_wr(eff_wr && cur_idx == A_GIDX), .idx_wdata(acc_wdata[GAW-1:0]),
    .dat_wr(eff_wr && cur_idx == A_GDAT), .dat_rd(eff_rd && cur_idx == A_GDAT),
    .dat_wdata(acc_wdata[7:0]), .idx_q(gidx_q), .dat_q(gdat_q)
  );

  rp_table #(.DEPTH(FILT_DEPTH), .DW(8), .GUARD(1'b1)) u_filt (
    .clk, .rst_n,
    .idx_wr(eff_wr && cur_idx == A_FIDX), .idx_wdata(acc_wdata[FAW-1:0]),
    .dat_wr(eff_wr && cur_idx == A_FDAT), .dat_rd(eff_rd && cur_idx == A_FDAT),
    .dat_wdata(acc_wdata[7:0]), .idx_q(fidx_q), .dat_q(fdat_q)
  );

  always_comb begin
    unique case (cur_idx)
      A_IDENT: rd_mux = IDENT_VAL;
      A_CFGRB: rd_mux = CFGRB_VAL;
      A_GIDX:  rd_mux = 8'(gidx_q);
      A_GDAT:  rd_mux = gdat_q;
      A_FIDX:  rd_mux = 8'(fidx_q);
      A_FDAT:  rd_mux = fdat_q;
      default: rd_mux = cfg_rd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      px_valid <= 1'b0;
      px_data  <= '0;
    end else begin
      rd_valid <= fire && !acc_write;
      if (fire && !acc_write)
        rd_data <= discard ? 16'h0000 : {8'h00, rd_mux};
      if (eff_wr && cur_idx == A_PIX) begin
        px_valid <= 1'b1;
        px_data  <= acc_wdata;
      end else if (px_ready)
        px_valid <= 1'b0;
    end
  end

  assign irq_pending = |irq_q;
endmodule

// File: rtl/regport_chk.sv
module regport_chk
  import regport_pkg::*;
#(
  parameter int SKIP_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic              acc_write,
  input logic              acc_dsel,
  input logic [15:0]       acc_wdata,
  input logic              rd_valid,
  input logic [15:0]       rd_data,
  input logic              px_valid,
  input logic              px_ready,
  input logic [15:0]       px_data,
  input idx_t              idx_q,
  input logic [SKIP_W-1:0] skip_q
);
  logic fire, live;
  assign fire = acc_valid && acc_ready;
  assign live = (skip_q == '0);

  // R1
  cmd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && live && acc_write && !acc_dsel |=> idx_q == $past(acc_wdata[7:0]));

  // R2
  data_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && live && acc_write && acc_dsel && !is_stream(idx_q) |=> idx_q == $past(idx_q) + 8'd2);

  // R2
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && live && acc_write && acc_dsel && is_stream(idx_q) |=> $stable(idx_q));

  // R3
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !acc_write |=> rd_valid);

  // R3
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && !acc_write) |=> !rd_valid);

  // R4
  skip_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !live |=> $stable(idx_q));

  // R4
  skip_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !live && !acc_write |=> rd_data == 16'h0000);

  // R12
  px_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid && !px_ready |=> px_valid && $stable(px_data));
endmodule

bind host_regport regport_chk #(.SKIP_W(SKIP_W)) u_chk (
  .clk, .rst_n, .acc_valid, .acc_ready, .acc_write, .acc_dsel, .acc_wdata,
  .rd_valid, .rd_data, .px_valid, .px_ready, .px_data,
  .idx_q(cur_idx), .skip_q(skip_cnt)
);

// File: tb/host_regport_tb_top.sv
`timescale 1ns/1ps
module host_regport_tb_top;
  localparam int SKIP_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0, acc_dsel = 1'b0;
  logic [15:0] acc_wdata = '0;
  logic skip_load = 1'b0;
  logic [SKIP_W-1:0] skip_count = '0;
  logic [7:0] irq_events = '0;
  logic px_ready = 1'b1;
  logic acc_ready, rd_valid, irq_pending, px_valid;
  logic [15:0] rd_data, px_data;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  host_regport dut_i (
    .clk, .rst_n, .acc_valid, .acc_ready, .acc_write, .acc_dsel, .acc_wdata,
    .rd_valid, .rd_data, .skip_load, .skip_count, .irq_events, .irq_pending,
    .px_valid, .px_ready, .px_data
  );

  // reference model
  logic [7:0]  m_idx;
  int          m_skip;
  logic [6:0]  m_div;
  logic [11:0] m_ref;
  logic [7:0]  m_tim, m_fcfg, m_irq, m_gidx;
  logic [3:0]  m_fmt;
  int          m_fidx;
  logic [7:0]  m_gam [256];
  logic [7:0]  m_filt [32];

  function automatic bit m_stream(input logic [7:0] a);
    return a == 8'h90 || a == 8'h5A || a == 8'hB8;
  endfunction

  function automatic logic [7:0] m_read_val(input logic [7:0] a);
    case (a)
      8'h00: return 8'hA5;
      8'h02: return 8'h83;
      8'h04: return {1'b1, m_div - 7'd1};
      8'h18: return m_ref[7:0];
      8'h1A: return {4'h0, m_ref[11:8]};
      8'h1E: return m_tim;
      8'h8C: return {4'h0, m_fmt};
      8'h56: return m_fcfg;
      8'h58: return 8'(m_fidx);
      8'h5A: return (m_fidx < 32) ? m_filt[m_fidx] : 8'h00;
      8'hB6: return m_gidx;
      8'hB8: return m_gam[m_gidx];
      8'hF6: return m_irq;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] a);
    case (a)
      8'h00, 8'h02, 8'h90: return "R5";
      8'h04: return "R6";
      8'h18, 8'h1A: return "R7";
      8'h1E, 8'h8C, 8'h56: return "R8";
      8'hB6, 8'hB8: return "R9";
      8'h58, 8'h5A: return "R10";
      8'hF6: return "R11";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic reset_model();
    m_idx = 8'h00; m_skip = 0; m_div = 7'd9; m_ref = 12'h25C; m_tim = 8'h13;
    m_fmt = 4'd3; m_fcfg = 8'h80; m_irq = 8'h00; m_gidx = 8'h00; m_fidx = 0;
    for (int i = 0; i < 256; i++) m_gam[i] = 8'h00;
    for (int i = 0; i < 32; i++) m_filt[i] = 8'h00;
  endtask

  // one transfer; called and returns at a falling edge
  task automatic access(input bit wr, input bit dsel, input logic [15:0] d,
                        input string tag, output logic [15:0] got);
    logic [7:0] exp;
    bit px_exp, rd_chk;
    exp = 8'h00; px_exp = 1'b0; rd_chk = !wr;
    if (m_skip > 0) begin
      m_skip--;
    end else if (wr && !dsel) begin
      m_idx = d[7:0];
    end else if (wr) begin
      case (m_idx)
        8'h04: m_div = 7'(d[7:0] & 8'h3F) + 7'd1;
        8'h18: m_ref[7:0] = d[7:0];
        8'h1A: m_ref[11:8] = d[3:0];
        8'h1E: m_tim = d[7:0] & 8'h17;
        8'h8C: m_fmt = d[3:0];
        8'h56: m_fcfg = d[7:0] & 8'hBF;
        8'h58: m_fidx = int'(d[4:0]);
        8'h5A: if (m_fidx < 32) begin m_filt[m_fidx] = d[7:0]; m_fidx++; end
        8'hB6: m_gidx = d[7:0];
        8'hB8: begin m_gam[m_gidx] = d[7:0]; m_gidx++; end
        8'hF6: m_irq = m_irq & d[7:0];
        8'h90: px_exp = 1'b1;
        default: ;
      endcase
      if (!m_stream(m_idx)) m_idx = m_idx + 8'd2;
    end else begin
      exp = m_read_val(m_idx);
      if (m_idx == 8'h5A && m_fidx < 32) m_fidx++;
      if (m_idx == 8'hB8) m_gidx++;
      if (dsel) m_idx = m_idx + 8'd1;
    end
    acc_valid = 1'b1; acc_write = wr; acc_dsel = dsel; acc_wdata = d;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    got = rd_data;
    if (rd_chk) check(tag, {15'h0, rd_valid, rd_data}, {15'h0, 1'b1, 8'h00, exp});
    if (px_exp) check("R12 px word", {15'h0, px_valid, px_data}, {15'h0, 1'b1, d});
  endtask

  task automatic cmd(input logic [7:0] a);
    logic [15:0] g;
    access(1'b1, 1'b0, {8'h00, a}, "R1", g);
  endtask

  task automatic wr(input logic [15:0] d);
    logic [15:0] g;
    access(1'b1, 1'b1, d, "R2", g);
  endtask

  task automatic rd(input bit dsel, input string tag, output logic [15:0] g);
    access(1'b0, dsel, 16'h0, tag, g);
  endtask

  task automatic load_skip(input int c);
    skip_load = 1'b1; skip_count = SKIP_W'(c);
    @(posedge clk); @(negedge clk);
    skip_load = 1'b0;
    m_skip = c;
  endtask

  task automatic pulse_irq(input logic [7:0] v);
    irq_events = v;
    @(posedge clk); @(negedge clk);
    irq_events = 8'h00;
    m_irq = m_irq | v;
    check("R11 pending", {31'h0, irq_pending}, {31'h0, m_irq != 8'h00});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] g;
    logic [7:0] addrs [16];
    addrs = '{8'h00, 8'h02, 8'h04, 8'h18, 8'h1A, 8'h1E, 8'h56, 8'h58,
              8'h5A, 8'h8C, 8'h90, 8'hB6, 8'hB8, 8'hF6, 8'h44, 8'h03};
    reset_model();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state of outputs
    check("R1 reset outputs", {28'h0, acc_ready, rd_valid, px_valid, irq_pending}, 32'h8);
    // R1 reset index 0, R3 read advance by 1
    rd(1'b1, "R1 index0 ident", g); check("R5 ident", g, 32'hA5);
    rd(1'b1, "R3 odd index", g);    check("R3 odd index zero", g, 32'h0);
    rd(1'b1, "R3 step", g);         check("R5 cfg readback", g, 32'h83);
    // R3 command-mode read leaves index
    cmd(8'h8C);
    rd(1'b0, "R3 dsel0", g); rd(1'b0, "R3 dsel0 again", g);
    check("R8 format reset", g, 32'h3);
    // R6 divider
    cmd(8'h04); rd(1'b0, "R6 reset", g); check("R6 reset read", g, 32'h88);
    wr(16'h00FF);
    cmd(8'h04); rd(1'b0, "R6 written", g); check("R6 written read", g, 32'hBF);
    // R7 split refresh, R2 +2 step between halves
    cmd(8'h18); rd(1'b1, "R7 lo reset", g); check("R7 lo reset", g, 32'h5C);
    cmd(8'h1A); rd(1'b1, "R7 hi reset", g); check("R7 hi reset", g, 32'h02);
    cmd(8'h18); wr(16'h12AB); wr(16'hFFF7);
    cmd(8'h18); rd(1'b0, "R7 lo", g); check("R7 lo new", g, 32'hAB);
    cmd(8'h1A); rd(1'b0, "R7 hi", g); check("R7 hi new", g, 32'h07);
    // R8 masks
    cmd(8'h1E); rd(1'b0, "R8 timing reset", g);
    wr(16'hFFFF); cmd(8'h1E); rd(1'b0, "R8 timing", g); check("R8 timing mask", g, 32'h17);
    cmd(8'h56); rd(1'b0, "R8 filter cfg reset", g);
    wr(16'hFFFF); cmd(8'h56); rd(1'b0, "R8 filter cfg", g); check("R8 fcfg mask", g, 32'hBF);
    cmd(8'h8C); wr(16'hFFF5); cmd(8'h8C); rd(1'b0, "R8 format", g); check("R8 format mask", g, 32'h5);
    // R9 gamma fill, index held on stream port (R2)
    cmd(8'hB6); wr(16'h0000);
    cmd(8'hB8);
    for (int i = 0; i < 256; i++) wr(16'((i * 37 + 11) & 8'hFF));
    cmd(8'hB6); rd(1'b0, "R9 index wrapped", g); check("R9 wrap to 0", g, 32'h0);
    wr(16'h00FE);
    cmd(8'hB8);
    rd(1'b1, "R9 entry FE", g); check("R9 entry FE", g, 32'((254 * 37 + 11) & 8'hFF));
    cmd(8'hB8); rd(1'b0, "R9 entry FF", g); rd(1'b0, "R9 entry 00", g);
    check("R9 entry 00", g, 32'd11);
    // R10 filter table and guard
    cmd(8'h58); wr(16'h00FF); cmd(8'h58); rd(1'b0, "R10 index mask", g);
    check("R10 index masked", g, 32'h1F);
    wr(16'h0000); cmd(8'h5A);
    for (int i = 0; i < 32; i++) wr(16'(i * 5 + 1));
    cmd(8'h58); rd(1'b0, "R10 index dead", g); check("R10 index 32", g, 32'h20);
    cmd(8'h5A); rd(1'b0, "R10 dead read", g); check("R10 dead read 0", g, 32'h0);
    wr(16'h00AA);
    cmd(8'h58); rd(1'b0, "R10 dead stays", g); check("R10 stays 32", g, 32'h20);
    wr(16'h001E); cmd(8'h5A);
    rd(1'b0, "R10 entry 30", g); check("R10 entry 30", g, 32'd151);
    rd(1'b0, "R10 entry 31", g); rd(1'b0, "R10 past end", g);
    // R11 interrupt status
    pulse_irq(8'hA5);
    cmd(8'hF6); rd(1'b0, "R11 status", g); check("R11 status set", g, 32'hA5);
    wr(16'hFF0F); cmd(8'hF6); rd(1'b0, "R11 and-clear", g); check("R11 partial clear", g, 32'h05);
    wr(16'h0000);
    check("R11 pending low", {31'h0, irq_pending}, 32'h0);
    // R4 skip
    cmd(8'h8C);
    load_skip(3);
    cmd(8'h00); rd(1'b1, "R4 swallowed read", g); check("R4 read zero", g, 32'h0);
    wr(16'h000A);
    rd(1'b0, "R4 after skip", g); check("R4 untouched", g, 32'h5);
    // R5 unknown and pixel readback
    cmd(8'h44); wr(16'hFFFF); cmd(8'h44); rd(1'b0, "R5 unknown", g); check("R5 unknown zero", g, 32'h0);
    cmd(8'h00); wr(16'h1234); cmd(8'h00); rd(1'b0, "R5 ident write ignored", g);
    cmd(8'h90); rd(1'b0, "R5 pixel read", g);
    // R12 back-pressure
    px_ready = 1'b0;
    wr(16'hBEEF);
    check("R12 stall ready", {31'h0, acc_ready}, 32'h0);
    @(negedge clk);
    check("R12 held", {15'h0, px_valid, px_data}, {15'h0, 1'b1, 16'hBEEF});
    px_ready = 1'b1;
    #0.1;
    check("R12 ready back", {31'h0, acc_ready}, 32'h1);
    @(negedge clk);
    check("R12 drained", {31'h0, px_valid}, 32'h0);
    // random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(99, 0));
      if (r < 15) cmd(addrs[$urandom_range(15, 0)]);
      else if (r < 20) load_skip(int'($urandom_range(3, 0)));
      else if (r < 24) pulse_irq(8'($urandom()));
      else if (r < 60) wr(16'($urandom()));
      else begin
        logic [7:0] a;
        a = m_idx;
        rd($urandom_range(9, 0) != 0, (m_skip > 0) ? "R4" : req_of(a), g);
      end
    end
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule